// File: doc/BRIEF.md
# Flash Command Interface Controller

This block models the control side of an automated parallel flash memory at the cycle level. Bus cycles are decoded from active-low chip select (`ce_n`), output enable (`oe_n`), write strobe (`we_n`), reset/power-down (`rp_n`) and boot-block protect (`wp_n`) pins. A command is taken when `we_n` rises while `ce_n` is low. A state machine then picks what a read returns: array data, identifier codes or the status byte. Word writes and block erases each take two command cycles. Each runs a timed busy phase, during which the `ready` output is low. A small register array stands in for the storage cells. Supply sensing is reduced to two digital lockout flags.

The states are named `ST_ARRAY`, `ST_IDENT`, `ST_STATUS` (the read modes), `ST_WR_SETUP` and `ST_ER_SETUP` (waiting for the second command cycle), `ST_WR_BUSY` and `ST_ER_BUSY` (timed operation), `ST_PWRDN` (valid deep power-down) and `ST_WAKE` (wake-up delay).

The transitions are:
- From a read mode: FFh goes to array, 90h to identifier, 70h to status, 40h to write setup and 20h to erase setup.
- From a setup state, the second cycle goes to a busy state, or to status on an error.
- A busy state goes to status when its timer ends.
- Any state goes to power-down on a valid reset.
- Power-down goes to wake when `rp_n` rises.
- Wake goes to array when the delay expires.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: `dout_oe` is 1 only when `ce_n`=0, `oe_n`=1'b0, `we_n`=1 and `rp_n`=1, and never in power-down or wake-up. With `ce_n`=1 it is 0 whatever `oe_n` is.
- R2: In a read mode, a command cycle with data FFh selects array reads, 90h selects identifier reads and 70h selects status reads. In identifier mode, address bit 0 = 0 returns `MFR_ID` (B0h by default) and address bit 0 = 1 returns `DEV_ID` (1Ch). Any other code leaves the mode unchanged.
- R3: A 40h cycle followed by a data cycle stores that data at the address of the second cycle. `ready` is low for exactly `PGM_CYC` cycles, counted from the clock edge that takes the second cycle. Afterwards reads return the status byte.
- R4: A 20h cycle followed by a D0h cycle sets every word of the addressed block (the top `BLK_BITS` address bits) to FFh. `ready` is low for exactly `ERS_CYC` cycles, and the other blocks are unchanged.
- R5: If the second erase cycle carries anything other than D0h, nothing is erased and status bits 5 and 4 are set.
- R6: If `vpp_lock` or `vcc_lock` is high at the second cycle, the operation is suppressed and status bit 3 is set. Bit 4 is also set for a write and bit 5 for an erase.
- R7: With `wp_n`=0, an operation aimed at block `BOOT_BLK` (0) is suppressed. Status bit 1 is set, together with bit 4 for a write or bit 5 for an erase.
- R8: The status byte has bit 7 = 1 when the block is ready and 0 while it is busy. Bits 5, 4, 3 and 1 are sticky until a valid reset, and all other bits read 0.
- R9: Raising `ce_n` during a busy phase does not stop it, and the operation completes.
- R10: An `rp_n` low period of at most `RST_MIN` clock edges blocks outputs and command cycles while it lasts. Apart from that it changes nothing, and a busy operation keeps running.
- R11: `rp_n` held low for more than `RST_MIN` edges is a valid reset. It aborts a busy operation, and `ready` then stays low until the wake-up delay ends. After wake-up the block is in array mode with status 80h.
- R12: Command cycles issued during the `WAKE_CYC` wake-up delay after a valid reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; a command is taken on its rising edge |
| rp_n | input | 1 | Reset / deep power-down, active low |
| wp_n | input | 1 | Boot-block protect, active low |
| vpp_lock | input | 1 | Program supply below lockout level |
| vcc_lock | input | 1 | Core supply below lockout level |
| addr | input | AW | Word address |
| din | input | DW | Command / write data |
| dout | output | DW | Read data |
| dout_oe | output | 1 | Data bus drive enable |
| ready | output | 1 | High when no operation is in progress |

## Verification
A wrong state shows on the ports within one cycle as the wrong read source. For example, array data appears where the status byte is expected, or identifier codes appear where array data is expected. The read after any command therefore exposes a mis-decode at once. A timer or abort fault shows as a `ready` low window that differs from `PGM_CYC` or `ERS_CYC` edges, or that ends before wake-up completes; the bench counts that window edge by edge. Lost or misplaced array updates stay hidden until a later array read, so full readback sweeps follow each write and erase pass.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        ST_ARRAY,
        ST_IDENT,
        ST_STATUS,
        ST_WR_SETUP,
        ST_ER_SETUP,
        ST_WR_BUSY,
        ST_ER_BUSY,
        ST_PWRDN,
        ST_WAKE
    } cmd_state_e;

    localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_READ_ID     = 8'h90;
    localparam logic [7:0] OP_READ_STATUS = 8'h70;
    localparam logic [7:0] OP_WORD_WRITE  = 8'h40;
    localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;

    typedef struct packed {
        logic ers_err;   // status bit 5
        logic wr_err;    // status bit 4
        logic supply;    // status bit 3
        logic prot;      // status bit 1
    } err_flags_t;

    function automatic logic [7:0] pack_status(input logic rdy, input err_flags_t f);
        return {rdy, 1'b0, f.ers_err, f.wr_err, f.supply, 1'b0, f.prot, 1'b0};
    endfunction

endpackage

// File: rtl/flash_bus_decode.sv
module flash_bus_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic rp_n,
    input  logic out_gate,
    output logic wr_stb,
    output logic rd_en
);

    logic we_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q <= 1'b1;
        end else begin
            we_q <= we_n;
        end
    end

    // Command cycle: rising write strobe while selected and not held in reset
    assign wr_stb = !ce_n && we_n && !we_q && rp_n;
    assign rd_en  = !ce_n && !oe_n && we_n && rp_n && !out_gate;

endmodule

// File: rtl/flash_pd_ctrl.sv
module flash_pd_ctrl #(
    parameter int RST_MIN  = 4,
    parameter int WAKE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rp_n,
    output logic pd_valid,
    output logic wake_busy
);

    localparam int LW = $clog2(RST_MIN + 1);
    localparam int WW = $clog2(WAKE_CYC + 1);

    logic [LW-1:0] lo_cnt_q;
    logic [WW-1:0] wake_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt_q   <= '0;
            wake_cnt_q <= '0;
        end else if (!rp_n) begin
            if (lo_cnt_q != LW'(RST_MIN)) begin
                lo_cnt_q <= lo_cnt_q + LW'(1);
            end
            wake_cnt_q <= '0;
        end else begin
            lo_cnt_q <= '0;
            if (lo_cnt_q == LW'(RST_MIN)) begin
                wake_cnt_q <= WW'(WAKE_CYC);
            end else if (wake_cnt_q != '0) begin
                wake_cnt_q <= wake_cnt_q - WW'(1);
            end
        end
    end

    assign pd_valid  = !rp_n && (lo_cnt_q == LW'(RST_MIN));
    assign wake_busy = (wake_cnt_q != '0);

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
    parameter int AW       = 4,
    parameter int DW       = 8,
    parameter int BLK_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    input  logic                ers_en,
    input  logic [BLK_BITS-1:0] ers_blk,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data
);

    localparam int DEPTH = 1 << AW;
    localparam int SHIFT = AW - BLK_BITS;

    logic [DEPTH*DW-1:0] flat;

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        localparam logic [BLK_BITS-1:0] MY_BLK = BLK_BITS'(w >> SHIFT);
        logic [DW-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '1;
            end else if (wr_en && (wr_addr == AW'(w))) begin
                word_q <= wr_data;
            end else if (ers_en && (ers_blk == MY_BLK)) begin
                word_q <= '1;
            end
        end

        assign flat[w*DW +: DW] = word_q;
    end

    assign rd_data = flat[rd_addr*DW +: DW];

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int          AW       = 4,
    parameter int          DW       = 8,
    parameter int          BLK_BITS = 2,
    parameter int          BOOT_BLK = 0,
    parameter int          PGM_CYC  = 5,
    parameter int          ERS_CYC  = 9,
    parameter int          RST_MIN  = 4,
    parameter int          WAKE_CYC = 3,
    parameter logic [7:0]  MFR_ID   = 8'hB0,
    parameter logic [7:0]  DEV_ID   = 8'h1C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          rp_n,
    input  logic          wp_n,
    input  logic          vpp_lock,
    input  logic          vcc_lock,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    output logic          ready
);

    localparam int MAXC = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
    localparam int TW   = $clog2(MAXC + 1);
    localparam int SHIFT = AW - BLK_BITS;

    cmd_state_e          state_q, state_d;
    logic [TW-1:0]       tmr_q, tmr_d;
    logic [AW-1:0]       lat_addr_q, lat_addr_d;
    logic [DW-1:0]       lat_data_q, lat_data_d;
    err_flags_t          flags_q, flags_d;
    logic                abort_q, abort_d;
    logic                arr_wr, arr_ers;
    logic                wr_stb, rd_en, out_gate;
    logic                pd_valid, wake_busy;
    logic [DW-1:0]       arr_rd;
    logic [7:0]          cmd;
    logic                supply_lock, prot_hit, busy;
    logic [7:0]          stat8;

    assign cmd         = din[7:0];
    assign supply_lock = vpp_lock || vcc_lock;
    assign prot_hit    = !wp_n && (addr[AW-1 -: BLK_BITS] == BLK_BITS'(BOOT_BLK));
    assign busy        = (state_q == ST_WR_BUSY) || (state_q == ST_ER_BUSY);
    assign out_gate    = (state_q == ST_PWRDN) || (state_q == ST_WAKE);

    flash_bus_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .rp_n     (rp_n),
        .out_gate (out_gate),
        .wr_stb   (wr_stb),
        .rd_en    (rd_en)
    );

    flash_pd_ctrl #(
        .RST_MIN  (RST_MIN),
        .WAKE_CYC (WAKE_CYC)
    ) u_pd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rp_n      (rp_n),
        .pd_valid  (pd_valid),
        .wake_busy (wake_busy)
    );

    flash_cell_array #(
        .AW       (AW),
        .DW       (DW),
        .BLK_BITS (BLK_BITS)
    ) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (arr_wr),
        .wr_addr (lat_addr_q),
        .wr_data (lat_data_q),
        .ers_en  (arr_ers),
        .ers_blk (lat_addr_q[AW-1 -: BLK_BITS]),
        .rd_addr (addr),
        .rd_data (arr_rd)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_ARRAY;
            tmr_q      <= '0;
            lat_addr_q <= '0;
            lat_data_q <= '0;
            flags_q    <= '0;
            abort_q    <= 1'b0;
        end else begin
            state_q    <= state_d;
            tmr_q      <= tmr_d;
            lat_addr_q <= lat_addr_d;
            lat_data_q <= lat_data_d;
            flags_q    <= flags_d;
            abort_q    <= abort_d;
        end
    end

    // Next state
    always_comb begin
        state_d    = state_q;
        tmr_d      = tmr_q;
        lat_addr_d = lat_addr_q;
        lat_data_d = lat_data_q;
        flags_d    = flags_q;
        abort_d    = abort_q;
        arr_wr     = 1'b0;
        arr_ers    = 1'b0;
        if (pd_valid && (state_q != ST_PWRDN)) begin
            state_d = ST_PWRDN;
            abort_d = abort_q || busy;
        end else begin
            unique case (state_q)
                ST_ARRAY, ST_IDENT, ST_STATUS: begin
                    if (wr_stb) begin
                        unique case (cmd)
                            OP_READ_ARRAY:  state_d = ST_ARRAY;
                            OP_READ_ID:     state_d = ST_IDENT;
                            OP_READ_STATUS: state_d = ST_STATUS;
                            OP_WORD_WRITE:  state_d = ST_WR_SETUP;
                            OP_ERASE_SETUP: state_d = ST_ER_SETUP;
                            default:        state_d = state_q;
                        endcase
                    end
                end
                ST_WR_SETUP: begin
                    if (wr_stb) begin
                        lat_addr_d = addr;
                        lat_data_d = din;
                        if (supply_lock) begin
                            flags_d.supply = 1'b1;
                            flags_d.wr_err = 1'b1;
                            state_d        = ST_STATUS;
                        end else if (prot_hit) begin
                            flags_d.prot   = 1'b1;
                            flags_d.wr_err = 1'b1;
                            state_d        = ST_STATUS;
                        end else begin
                            tmr_d   = TW'(PGM_CYC);
                            state_d = ST_WR_BUSY;
                        end
                    end
                end
                ST_ER_SETUP: begin
                    if (wr_stb) begin
                        lat_addr_d = addr;
                        if (cmd != OP_ERASE_GO) begin
                            flags_d.ers_err = 1'b1;
                            flags_d.wr_err  = 1'b1;
                            state_d         = ST_STATUS;
                        end else if (supply_lock) begin
                            flags_d.supply  = 1'b1;
                            flags_d.ers_err = 1'b1;
                            state_d         = ST_STATUS;
                        end else if (prot_hit) begin
                            flags_d.prot    = 1'b1;
                            flags_d.ers_err = 1'b1;
                            state_d         = ST_STATUS;
                        end else begin
                            tmr_d   = TW'(ERS_CYC);
                            state_d = ST_ER_BUSY;
                        end
                    end
                end
                ST_WR_BUSY: begin
                    if (tmr_q == TW'(1)) begin
                        arr_wr  = 1'b1;
                        state_d = ST_STATUS;
                    end else begin
                        tmr_d = tmr_q - TW'(1);
                    end
                end
                ST_ER_BUSY: begin
                    if (tmr_q == TW'(1)) begin
                        arr_ers = 1'b1;
                        state_d = ST_STATUS;
                    end else begin
                        tmr_d = tmr_q - TW'(1);
                    end
                end
                ST_PWRDN: begin
                    if (!pd_valid) begin
                        state_d = ST_WAKE;
                    end
                end
                ST_WAKE: begin
                    if (!wake_busy) begin
                        state_d = ST_ARRAY;
                        flags_d = '0;
                        abort_d = 1'b0;
                    end
                end
                default: state_d = ST_ARRAY;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ready   = !busy && !abort_q;
        stat8   = pack_status(ready, flags_q);
        dout_oe = rd_en;
        unique case (state_q)
            ST_ARRAY: dout = arr_rd;
            ST_IDENT: dout = addr[0] ? DW'(DEV_ID) : DW'(MFR_ID);
            default:  dout = DW'(stat8);
        endcase
    end

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
    import flash_cmd_pkg::*;
#(
    parameter int TW = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       we_n,
    input logic       rp_n,
    input logic       dout_oe,
    input logic       ready,
    input cmd_state_e state_q,
    input logic       pd_valid,
    input logic [TW-1:0] tmr_q,
    input err_flags_t flags_q,
    input logic       arr_wr
);

    p_oe_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!ce_n && !oe_n && we_n && rp_n));

    p_busy_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_BUSY || state_q == ST_ER_BUSY) |-> !ready);

    p_store_then_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr && !pd_valid) |=> (state_q == ST_STATUS));

    p_ce_continue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_BUSY && tmr_q > TW'(1) && !pd_valid) |=> (state_q == ST_WR_BUSY));

    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WR_BUSY || state_q == ST_ER_BUSY) && pd_valid)
        |=> (state_q == ST_PWRDN && !ready));

    p_wake_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARRAY && $past(state_q) == ST_WAKE) |-> (flags_q == '0 && ready));

    p_wake_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE && rp_n) |=> (state_q == ST_WAKE || state_q == ST_ARRAY));

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.TW(TW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .rp_n     (rp_n),
    .dout_oe  (dout_oe),
    .ready    (ready),
    .state_q  (state_q),
    .pd_valid (pd_valid),
    .tmr_q    (tmr_q),
    .flags_q  (flags_q),
    .arr_wr   (arr_wr)
);

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW       = 4;
    localparam int DW       = 8;
    localparam int PGM_CYC  = 5;
    localparam int ERS_CYC  = 9;
    localparam int RST_MIN  = 4;
    localparam int WAKE_CYC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rp_n = 1'b1, wp_n = 1'b1;
    logic vpp_lock = 1'b0, vcc_lock = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_oe, ready;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_ctrl u_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .rp_n(rp_n), .wp_n(wp_n), .vpp_lock(vpp_lock), .vcc_lock(vcc_lock),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .ready(ready)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 37 + 5);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        #1;
        d = dout; oe = dout_oe;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (!ready && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic valid_reset();
        rp_n = 1'b0;
        repeat (RST_MIN + 4) @(negedge clk);
        rp_n = 1'b1;
        repeat (WAKE_CYC + 3) @(negedge clk);
    endtask

    task automatic read_check(input string req, input int a, input int exp);
        logic [7:0] d;
        logic oe;
        bus_read(AW'(a), d, oe);
        check(req, {23'd0, oe, d}, {23'd0, 1'b1, 8'(exp)});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int n;
        logic [7:0] d;
        logic oe;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state: ready, status 80h (R8, R11)
        check("R8 ready after reset", ready, 1);
        bus_write(0, 8'h70);
        read_check("R8 status after reset", 0, 8'h80);
        bus_write(0, 8'hFF);
        read_check("R2 erased array after reset", 3, 8'hFF);

        // R1: sweep all pin combinations in array mode
        din = 8'hFF;
        for (int i = 0; i < 16; i++) begin
            ce_n = i[3]; oe_n = i[2]; we_n = i[1]; rp_n = i[0];
            #1;
            check("R1 output enable", dout_oe,
                  int'(!i[3] && !i[2] && i[1] && i[0]));
            @(negedge clk);
        end
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; rp_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2: identifier and status modes
        bus_write(0, 8'h90);
        read_check("R2 manufacturer code", 0, 8'hB0);
        read_check("R2 device code", 1, 8'h1C);
        bus_write(0, 8'h70);
        read_check("R2 status mode", 5, 8'h80);
        bus_write(0, 8'hFF);

        // R3/R9: write every word; ce_n is high for the whole busy phase
        for (int a = 0; a < 16; a++) begin
            bus_write(AW'(a), 8'h40);
            bus_write(AW'(a), pat(a));
            busy_len(n);
            check("R3 write busy length", n, PGM_CYC);
        end
        read_check("R3 status after write", 2, 8'h80);
        bus_write(0, 8'hFF);
        for (int a = 0; a < 16; a++) read_check("R3 R9 readback", a, pat(a));

        // R2: unknown code ignored
        bus_write(0, 8'h55);
        read_check("R2 unknown code ignored", 3, pat(3));

        // R4: erase blocks 1..3
        for (int b = 1; b < 4; b++) begin
            bus_write(AW'(b << 2), 8'h20);
            bus_write(AW'(b << 2), 8'hD0);
            busy_len(n);
            check("R4 erase busy length", n, ERS_CYC);
        end
        bus_write(0, 8'hFF);
        for (int a = 0; a < 16; a++)
            read_check("R4 erase readback", a, (a < 4) ? pat(a) : 8'hFF);

        // R8: status while busy has bit 7 clear
        bus_write(5, 8'h40);
        bus_write(5, 8'h3C);
        read_check("R8 status while busy", 0, 8'h00);
        busy_len(n);
        read_check("R8 status when done", 0, 8'h80);
        bus_write(0, 8'hFF);
        read_check("R3 second write", 5, 8'h3C);

        // R7: boot block protection
        wp_n = 1'b0;
        bus_write(2, 8'h40);
        bus_write(2, 8'h00);
        check("R7 no busy on protected write", ready, 1);
        read_check("R7 write protect status", 0, 8'h92);
        bus_write(0, 8'h20);
        bus_write(0, 8'hD0);
        read_check("R7 erase protect status sticky", 0, 8'hB2);
        bus_write(0, 8'hFF);
        read_check("R7 boot word kept", 2, pat(2));
        read_check("R7 boot word kept", 0, pat(0));
        wp_n = 1'b1;
        valid_reset();

        // R6: supply lockout
        vpp_lock = 1'b1;
        bus_write(9, 8'h40);
        bus_write(9, 8'h11);
        read_check("R6 vpp lockout status", 0, 8'h98);
        vpp_lock = 1'b0;
        bus_write(0, 8'hFF);
        read_check("R6 vpp lockout no write", 9, 8'hFF);
        valid_reset();
        vcc_lock = 1'b1;
        bus_write(0, 8'h20);
        bus_write(0, 8'hD0);
        read_check("R6 vcc lockout status", 0, 8'hA8);
        vcc_lock = 1'b0;
        bus_write(0, 8'hFF);
        read_check("R6 vcc lockout no erase", 0, pat(0));
        valid_reset();

        // R5: wrong confirm
        bus_write(0, 8'h20);
        bus_write(0, 8'h33);
        read_check("R5 bad confirm status", 0, 8'hB0);
        bus_write(0, 8'hFF);
        read_check("R5 no erase", 1, pat(1));
        valid_reset();

        // R10: short rp_n glitch during busy does not abort
        bus_write(6, 8'h40);
        bus_write(6, 8'h5A);
        rp_n = 1'b0;
        repeat (2) @(negedge clk);
        rp_n = 1'b1;
        busy_len(n);
        bus_write(0, 8'hFF);
        read_check("R10 write survives glitch", 6, 8'h5A);
        // command blocked while rp_n low (short)
        rp_n = 1'b0;
        bus_write(0, 8'h90);
        rp_n = 1'b1;
        @(negedge clk);
        read_check("R10 command blocked", 6, 8'h5A);

        // R11/R12: abort an erase with a valid reset
        bus_write(8, 8'h20);
        bus_write(8, 8'hD0);
        rp_n = 1'b0;
        ce_n = 1'b0; oe_n = 1'b0;
        repeat (RST_MIN + 6) @(negedge clk);
        check("R11 ready low in power-down", ready, 0);
        check("R11 outputs off in power-down", dout_oe, 0);
        ce_n = 1'b1; oe_n = 1'b1;
        rp_n = 1'b1;
        bus_write(0, 8'h70);
        check("R11 ready low during wake-up", ready, 0);
        repeat (WAKE_CYC + 1) @(negedge clk);
        check("R11 ready after wake-up", ready, 1);
        read_check("R12 wake-up command ignored", 6, 8'h5A);
        bus_write(0, 8'h70);
        read_check("R11 status after wake-up", 0, 8'h80);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule